// File: doc/BRIEF.md
# ACPI Sleep State Decoder

This block takes the three platform sleep-control lines (power-good, the S3 run line and the S5 run line), brings them into the local clock domain, filters out short disturbances and decodes the result into a registered system power state: S0 (working), S3 (suspend to memory) or S5 (soft off). From that state and the filtered control code it also issues a source request for two supply rails. The dual rail is fed either from main or from standby power. The memory rail is fed from main, from standby, or is switched off. Analog regulation, gate drive and switchover delays belong to the power stage that consumes these requests.

The decode depends on history. A system in soft off must never pass through suspend on its way back up, because the memory rail would then be switched onto standby while main power is still ramping. So once the block sits in S5, every code that would otherwise mean S3 leaves it in S5, and only the full-power code lets it out. The very first filtered code after reset is decoded directly, without this rule. A fault-disable input forces every rail request off without disturbing the tracked state.

The control code is the vector {power-good, S3 line, S5 line}, power-good in the most significant bit. A line that is high means not asleep at that level. Each synchronizer stage resets to 1, which matches the pulled-high level of an undriven line.

Top module: `acpi_sleep_decoder`

## Requirements
- R1: After reset, before the first filtered code is decoded, state_o reads S5 (2'd2), state_oh_o reads 3'b100 and both rail requests read off (2'b00).
- R2: Code 111 decodes to S0 (state_o 2'd0, state_oh_o 3'b001). In S0 both rails request main (2'b01).
- R3: Codes 001, 011 and 101 decode to S3 (2'd1, one-hot 3'b010) when the present state is S0 or S3. In S3 both rails request standby (2'b10).
- R4: Codes 000, 010 and 100 decode to S5 (2'd2, one-hot 3'b100). The memory rail is off and the dual rail requests standby.
- R5: Code 110 is treated as S5. The memory rail is off and the dual rail requests main.
- R6: While in S5, a change to 001, 011 or 101 leaves the state at S5 with the memory rail off and the dual rail on standby. Only 111 leaves S5.
- R7: The first code accepted after reset sets the state directly, so 101 held through reset yields S3.
- R8: A changed code that holds for fewer than STABLE_CYC clocks changes neither the state nor the rail requests, and it raises no change pulse.
- R9: state_chg_o pulses for exactly one clock on each change of state_o. A code change that keeps the same state gives no pulse.
- R10: One clock after fault_off_i is high, both rail requests are off and state_o is unchanged. When fault_off_i falls, the requests return to what the state calls for.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_pg_i | input | 1 | Power-good line, asynchronous (code bit 2) |
| ctl_s3_i | input | 1 | S3 run line, high = awake, asynchronous (code bit 1) |
| ctl_s5_i | input | 1 | S5 run line, high = awake, asynchronous (code bit 0) |
| fault_off_i | input | 1 | Synchronous fault disable, forces rail requests off |
| state_o | output | 2 | Power state: 0 = S0, 1 = S3, 2 = S5 |
| state_oh_o | output | 3 | One-hot state {S5, S3, S0} |
| state_chg_o | output | 1 | One-clock pulse on every state change |
| dual_src_o | output | 2 | Dual rail source: 00 off, 01 main, 10 standby |
| mem_src_o | output | 2 | Memory rail source: 00 off, 01 main, 10 standby |

## Verification
The bench builds the block with STABLE_CYC set to 5 and two synchronizer stages. With that setting a disturbance of four clocks can be placed just under the acceptance window, and every transition settles within about a dozen clocks. This makes it practical to walk through all eight codes from each reachable state, including the blocked S5 exits and the first decode after reset. The short window also lets the bench count change pulses across sequences where the state stays put.

// File: rtl/acpi_dec_pkg.sv
package acpi_dec_pkg;

    typedef enum logic [1:0] {
        ST_S0 = 2'd0,
        ST_S3 = 2'd1,
        ST_S5 = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_STBY = 2'b10
    } rail_src_e;

    localparam int CODE_W = 3;

    // bit positions inside the control code
    localparam int BIT_PG = 2;
    localparam int BIT_S3 = 1;
    localparam int BIT_S5 = 0;

    function automatic logic [2:0] state_onehot(input pwr_state_e st);
        logic [2:0] oh;
        oh = 3'b000;
        case (st)
            ST_S0:   oh = 3'b001;
            ST_S3:   oh = 3'b010;
            default: oh = 3'b100;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/acpi_sync.sv
module acpi_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= RST_VAL;
            else         stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/acpi_code_filter.sv
module acpi_code_filter #(
    parameter int WIDTH      = 3,
    parameter int STABLE_CYC = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] code_i,
    output logic [WIDTH-1:0] code_o,
    output logic             vld_o
);

    localparam int CNT_W = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(STABLE_CYC - 1);

    typedef struct packed {
        logic [WIDTH-1:0] cand;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] code;
        logic             vld;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d = filt_q;
        if (code_i != filt_q.cand) begin
            filt_d.cand = code_i;
            filt_d.cnt  = '0;
        end else if (filt_q.cnt != CNT_LIM) begin
            filt_d.cnt = filt_q.cnt + 1'b1;
        end else begin
            filt_d.code = filt_q.cand;
            filt_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            filt_q.cand <= '1;
            filt_q.cnt  <= '0;
            filt_q.code <= '1;
            filt_q.vld  <= 1'b0;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign code_o = filt_q.code;
    assign vld_o  = filt_q.vld;

    // R8
    code_only_after_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(filt_q.code) |-> ($past(filt_q.cnt) == CNT_LIM));

    // R8
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        filt_q.cnt <= CNT_LIM);

endmodule

// File: rtl/acpi_state_fsm.sv
module acpi_state_fsm
    import acpi_dec_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              vld_i,
    input  logic              fault_off_i,
    output pwr_state_e        state_o,
    output logic [2:0]        state_oh_o,
    output logic              chg_o,
    output rail_src_e         dual_o,
    output rail_src_e         mem_o
);

    typedef struct packed {
        pwr_state_e state;
        logic       seeded;
        logic [2:0] oh;
        logic       chg;
        rail_src_e  dual;
        rail_src_e  mem;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    pwr_state_e nxt_state;
    logic       code_sleep3;
    logic       main_ok;

    always_comb begin
        code_sleep3 = code_i[BIT_S5] && !(code_i[BIT_PG] && code_i[BIT_S3]);
        main_ok     = code_i[BIT_PG] && code_i[BIT_S3];

        nxt_state = fsm_q.state;
        if (vld_i) begin
            if (main_ok && code_i[BIT_S5]) begin
                nxt_state = ST_S0;
            end else if (code_sleep3) begin
                if (fsm_q.seeded && fsm_q.state == ST_S5) nxt_state = ST_S5;
                else                                     nxt_state = ST_S3;
            end else begin
                nxt_state = ST_S5;
            end
        end

        fsm_d        = fsm_q;
        fsm_d.state  = nxt_state;
        fsm_d.seeded = fsm_q.seeded | vld_i;
        fsm_d.oh     = state_onehot(nxt_state);
        fsm_d.chg    = (nxt_state != fsm_q.state);

        if (fault_off_i || !(fsm_q.seeded | vld_i)) begin
            fsm_d.dual = SRC_OFF;
            fsm_d.mem  = SRC_OFF;
        end else begin
            fsm_d.dual = main_ok ? SRC_MAIN : SRC_STBY;
            case (nxt_state)
                ST_S0:   fsm_d.mem = SRC_MAIN;
                ST_S3:   fsm_d.mem = SRC_STBY;
                default: fsm_d.mem = SRC_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.state  <= ST_S5;
            fsm_q.seeded <= 1'b0;
            fsm_q.oh     <= 3'b100;
            fsm_q.chg    <= 1'b0;
            fsm_q.dual   <= SRC_OFF;
            fsm_q.mem    <= SRC_OFF;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o    = fsm_q.state;
    assign state_oh_o = fsm_q.oh;
    assign chg_o      = fsm_q.chg;
    assign dual_o     = fsm_q.dual;
    assign mem_o      = fsm_q.mem;

    // R6
    no_s5_to_s3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.seeded && fsm_q.state == ST_S5) |=> (fsm_q.state != ST_S3));

    // R2
    mem_main_only_s0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.mem == SRC_MAIN) |-> (fsm_q.state == ST_S0));

    // R4
    mem_off_in_s5_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state == ST_S5) |-> (fsm_q.mem == SRC_OFF));

    // R9
    chg_marks_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsm_q.chg |-> (fsm_q.state != $past(fsm_q.state)));

    // R9
    change_has_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state != $past(fsm_q.state)) |-> fsm_q.chg);

    // R10
    fault_rails_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_off_i |=> (fsm_q.dual == SRC_OFF && fsm_q.mem == SRC_OFF));

    // R10
    fault_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_off_i && !vld_i) |=> $stable(fsm_q.state));

    // R2
    onehot_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(fsm_q.oh) && fsm_q.oh != 3'b000);

endmodule

// File: rtl/acpi_sleep_decoder.sv
module acpi_sleep_decoder
    import acpi_dec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctl_pg_i,
    input  logic       ctl_s3_i,
    input  logic       ctl_s5_i,
    input  logic       fault_off_i,
    output logic [1:0] state_o,
    output logic [2:0] state_oh_o,
    output logic       state_chg_o,
    output logic [1:0] dual_src_o,
    output logic [1:0] mem_src_o
);

    logic [CODE_W-1:0] raw_code;
    logic [CODE_W-1:0] sync_code;
    logic [CODE_W-1:0] filt_code;
    logic              filt_vld;
    pwr_state_e        st;
    rail_src_e         dual_src;
    rail_src_e         mem_src;

    assign raw_code = {ctl_pg_i, ctl_s3_i, ctl_s5_i};

    acpi_sync #(
        .WIDTH   (CODE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({CODE_W{1'b1}})
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_code),
        .sync_o  (sync_code)
    );

    acpi_code_filter #(
        .WIDTH      (CODE_W),
        .STABLE_CYC (STABLE_CYC)
    ) u_filter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (sync_code),
        .code_o (filt_code),
        .vld_o  (filt_vld)
    );

    acpi_state_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .code_i      (filt_code),
        .vld_i       (filt_vld),
        .fault_off_i (fault_off_i),
        .state_o     (st),
        .state_oh_o  (state_oh_o),
        .chg_o       (state_chg_o),
        .dual_o      (dual_src),
        .mem_o       (mem_src)
    );

    assign state_o    = st;
    assign dual_src_o = dual_src;
    assign mem_src_o  = mem_src;

    // R5
    unused_code_rails_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_src_o == SRC_OFF && dual_src_o == SRC_MAIN) |-> (state_o == ST_S5));

endmodule

// File: tb/acpi_sleep_decoder_tb.sv
`timescale 1ns/1ps
module acpi_sleep_decoder_tb;

    localparam int STABLE = 5;
    localparam int SETTLE = STABLE + 8;

    localparam logic [1:0] S0 = 2'd0, S3 = 2'd1, S5 = 2'd2;
    localparam logic [1:0] OFF = 2'b00, MAIN = 2'b01, STBY = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b1, s3 = 1'b1, s5 = 1'b1;
    logic fault = 1'b0;
    logic [1:0] state;
    logic [2:0] state_oh;
    logic       chg;
    logic [1:0] dual, mem;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;

    acpi_sleep_decoder #(
        .SYNC_STAGES (2),
        .STABLE_CYC  (STABLE)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ctl_pg_i    (pg),
        .ctl_s3_i    (s3),
        .ctl_s5_i    (s5),
        .fault_off_i (fault),
        .state_o     (state),
        .state_oh_o  (state_oh),
        .state_chg_o (chg),
        .dual_src_o  (dual),
        .mem_src_o   (mem)
    );

    always @(negedge clk) if (rst_n && chg) pulses++;

    function automatic logic [2:0] oh_of(input logic [1:0] st);
        return (st == S0) ? 3'b001 : (st == S3) ? 3'b010 : 3'b100;
    endfunction

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [1:0] st,
                           input logic [1:0] d, input logic [1:0] m);
        chk({req, " state"}, 32'(state), 32'(st));
        chk({req, " onehot"}, 32'(state_oh), 32'(oh_of(st)));
        chk({req, " dual"}, 32'(dual), 32'(d));
        chk({req, " mem"}, 32'(mem), 32'(m));
    endtask

    task automatic apply(input logic [2:0] code, input int hold);
        @(negedge clk);
        {pg, s3, s5} = code;
        repeat (hold) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        {pg, s3, s5} = code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 and R7
    task automatic t_reset_and_seed();
        do_reset(3'b101);
        @(negedge clk);
        chk_all("R1", S5, OFF, OFF);
        repeat (SETTLE) @(negedge clk);
        chk_all("R7", S3, STBY, STBY);
    endtask

    // R2, R3, R9
    task automatic t_s0_s3();
        int p;
        apply(3'b111, SETTLE);
        chk_all("R2", S0, MAIN, MAIN);
        for (int i = 0; i < 3; i++) begin
            logic [2:0] c;
            c = (i == 0) ? 3'b101 : (i == 1) ? 3'b001 : 3'b011;
            apply(3'b111, SETTLE);
            apply(c, SETTLE);
            chk_all("R3", S3, STBY, STBY);
        end
        p = pulses;
        apply(3'b101, SETTLE);
        apply(3'b001, SETTLE);
        chk("R9 same-state no pulse", 32'(pulses - p), 32'd0);
        p = pulses;
        apply(3'b111, SETTLE);
        chk("R9 single pulse", 32'(pulses - p), 32'd1);
    endtask

    // R4, R5
    task automatic t_s5_codes();
        for (int i = 0; i < 3; i++) begin
            logic [2:0] c;
            c = (i == 0) ? 3'b100 : (i == 1) ? 3'b000 : 3'b010;
            apply(3'b111, SETTLE);
            apply(c, SETTLE);
            chk_all("R4", S5, STBY, OFF);
        end
        apply(3'b111, SETTLE);
        apply(3'b110, SETTLE);
        chk_all("R5", S5, MAIN, OFF);
    endtask

    // R6
    task automatic t_block();
        int p;
        apply(3'b000, SETTLE);
        p = pulses;
        apply(3'b001, SETTLE);
        chk_all("R6 001", S5, STBY, OFF);
        apply(3'b011, SETTLE);
        chk_all("R6 011", S5, STBY, OFF);
        apply(3'b101, SETTLE);
        chk_all("R6 101", S5, STBY, OFF);
        chk("R6 no pulse", 32'(pulses - p), 32'd0);
        apply(3'b110, SETTLE);
        apply(3'b101, SETTLE);
        chk_all("R6 from 110", S5, STBY, OFF);
        apply(3'b111, SETTLE);
        chk_all("R6 exit", S0, MAIN, MAIN);
    endtask

    // R8
    task automatic t_glitch();
        int p;
        apply(3'b111, SETTLE);
        p = pulses;
        apply(3'b000, STABLE - 1);
        apply(3'b111, SETTLE);
        chk_all("R8", S0, MAIN, MAIN);
        chk("R8 no pulse", 32'(pulses - p), 32'd0);
    endtask

    // R10
    task automatic t_fault();
        apply(3'b111, SETTLE);
        @(negedge clk);
        fault = 1'b1;
        @(negedge clk);
        chk_all("R10 forced off", S0, OFF, OFF);
        apply(3'b101, SETTLE);
        chk_all("R10 state tracks", S3, OFF, OFF);
        @(negedge clk);
        fault = 1'b0;
        @(negedge clk);
        chk_all("R10 release", S3, STBY, STBY);
    endtask

    initial begin
        t_reset_and_seed();
        t_s0_s3();
        t_s5_codes();
        t_block();
        t_glitch();
        t_fault();
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

endmodule